// File: doc/BRIEF.md
# Programmable Periodic Interrupt Timer

This block raises a periodic interrupt request for a small processor system. A divisor register, reached over a simple synchronous register bus, selects how many pulses of a 32,768 Hz tick enable make up one period. The tick enable arrives as a single-cycle pulse in the system clock domain, so the whole block runs on one clock. With a divisor of N, a request is raised once every N ticks, which gives 32768/N requests per second. A divisor of zero stops the counter and produces no requests, so the timer adds no load to the processor while it is not needed.

The request output is a level. It stays high until software acknowledges it with an access to a dedicated register, because the processor may have that interrupt level masked for a while. A status register shows whether a request is pending and whether a further period ran out while it was still pending, which is an overrun. Writing a new divisor while a count is running restarts the count, so the new period begins at once. Writing zero also cancels any pending request.

Top module: `periodic_irq_timer`

## Requirements
- R1: After reset the divisor register reads 0x00, `irq` is low and the status register reads 0x00.
- R2: While the divisor is 0, `irq` stays low whatever the tick input does.
- R3: With a non-zero divisor N, the Nth tick pulse after the divisor write raises `irq` on the clock edge that samples it. Later requests follow every N ticks. Cycles in which `tick_en` is low do not advance the count.
- R4: Writing a non-zero divisor while a count is in progress restarts the count from zero, and the first request comes N new ticks after that write.
- R5: Once raised, `irq` stays high until an acknowledge access or a write of 0 to the divisor.
- R6: An acknowledge access clears both the pending bit and the overrun bit. With the default `ACK_ANY_ACCESS`=1, an acknowledge access is a read or a write at address 2. Reading address 2 returns 0x00.
- R7: Writing 0 to the divisor clears the pending bit, the overrun bit and the count on that same edge.
- R8: When a period ends while a request is still pending, the overrun bit is set. The overrun bit is never set without the pending bit.
- R9: Register map: address 0 is the divisor (read/write). Address 1 is the status register (read-only), with bit 0 = pending and bit 1 = overrun and all other bits 0. `bus_rdata` is 0 in any cycle without `bus_sel` and `bus_rd` both high.
- R10: If an acknowledge and the end of a period fall in the same cycle, the pending bit stays set and the overrun bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Single-cycle 32,768 Hz tick enable |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| irq | output | 1 | Active-high level interrupt request |

## Verification
The bench sweeps every divisor from 1 to 255. For each one it checks that no request appears after N-1 ticks and that one does appear on the Nth tick, and it does this for two periods in a row. A design with an off-by-one terminal count, or one that lost its phase at the acknowledge, would fail somewhere in that sweep. It rewrites a larger divisor with a smaller one partway through a count. A design that kept the old count would run on through the full 8-bit range and stay silent. It also targets the cases where an acknowledge and a period end meet in the same cycle, where a zero write lands on a pending request, and where ticks are spaced apart by idle cycles. Errors here would show up as lost requests, false overrun bits, or a count that advances without a tick.

// File: rtl/pit_pkg.sv
package pit_pkg;
   // Register offsets; the bench and software rely on these values.
   localparam logic [1:0] OFS_DIVISOR = 2'd0;
   localparam logic [1:0] OFS_STATUS  = 2'd1;
   localparam logic [1:0] OFS_ACK     = 2'd2;
   // Status bit positions
   localparam int unsigned STS_PEND_BIT = 0;
   localparam int unsigned STS_OVR_BIT  = 1;
endpackage

// File: rtl/pit_regbank.sv
module pit_regbank #(
   parameter int unsigned DIV_W          = 8,
   parameter int unsigned DATA_W         = 8,
   parameter int unsigned ADDR_W         = 2,
   parameter bit          ACK_ANY_ACCESS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              wr,
   input  logic              rd,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              pending,
   input  logic              overrun,
   output logic [DIV_W-1:0]  div_q,
   output logic              div_load,
   output logic              div_zero_load,
   output logic              ack_stb,
   output logic [DATA_W-1:0] rdata
);
   import pit_pkg::*;

   logic hit_div, hit_sts, hit_ack;

   assign hit_div = (addr == ADDR_W'(OFS_DIVISOR));
   assign hit_sts = (addr == ADDR_W'(OFS_STATUS));
   assign hit_ack = (addr == ADDR_W'(OFS_ACK));

   assign div_load      = sel && wr && hit_div;
   assign div_zero_load = div_load && (wdata[DIV_W-1:0] == '0);

   generate
      if (ACK_ANY_ACCESS) begin : g_ack_any
         assign ack_stb = sel && (wr || rd) && hit_ack;
      end else begin : g_ack_wr
         assign ack_stb = sel && wr && hit_ack;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        div_q <= '0;
      else if (div_load) div_q <= wdata[DIV_W-1:0];
   end

   always_comb begin
      rdata = '0;
      if (sel && rd) begin
         if (hit_div) begin
            rdata[DIV_W-1:0] = div_q;
         end else if (hit_sts) begin
            rdata[STS_PEND_BIT] = pending;
            rdata[STS_OVR_BIT]  = overrun;
         end
      end
   end
endmodule

// File: rtl/pit_divider.sv
module pit_divider #(
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic [DIV_W-1:0] div_q,
   input  logic             load,
   output logic             expire
);
   logic [DIV_W-1:0] cnt;
   logic             running;
   logic             at_end;

   assign running = (div_q != '0);
   assign at_end  = (cnt == div_q - DIV_W'(1));
   assign expire  = tick_en && running && at_end && !load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt <= '0;
      else if (load)                 cnt <= '0;
      else if (tick_en && running)   cnt <= at_end ? '0 : cnt + DIV_W'(1);
   end

   // R3: count stays inside the current period
   p_cnt_in_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (div_q != '0) |-> (cnt < div_q));
   // R4: a divisor write restarts the count
   p_load_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt == '0));
   // R3: no advance without a tick
   p_no_tick_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !load) |=> $stable(cnt));
endmodule

// File: rtl/pit_request.sv
module pit_request (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic ack,
   input  logic clr,
   output logic pending,
   output logic overrun
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending <= 1'b0;
         overrun <= 1'b0;
      end else if (clr) begin
         pending <= 1'b0;
         overrun <= 1'b0;
      end else begin
         if (ack) begin
            pending <= expire;
            overrun <= 1'b0;
         end else if (expire) begin
            pending <= 1'b1;
            overrun <= overrun | pending;
         end
      end
   end

   // R5: a request holds until acknowledged or cancelled
   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && !ack && !clr) |=> pending);
   // R6: acknowledge clears overrun
   p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !overrun);
   // R7: zero write cancels everything
   p_zero_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!pending && !overrun));
   // R8: overrun implies pending
   p_ovr_implies_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |-> pending);
   // R10: coincident acknowledge and expiry
   p_ack_meets_expiry_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && expire && !clr) |=> (pending && !overrun));
endmodule

// File: rtl/periodic_irq_timer.sv
module periodic_irq_timer #(
   parameter int unsigned DIV_W          = 8,
   parameter int unsigned DATA_W         = 8,
   parameter int unsigned ADDR_W         = 2,
   parameter bit          ACK_ANY_ACCESS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   localparam int unsigned STS_BITS = 2;

   generate
      if (DIV_W < 2 || DIV_W > 16) begin : g_bad_div_w
         $error("DIV_W must lie in 2..16");
      end
      if (DATA_W < DIV_W || DATA_W < STS_BITS) begin : g_bad_data_w
         $error("DATA_W must hold the divisor and the status bits");
      end
      if (ADDR_W < 2) begin : g_bad_addr_w
         $error("ADDR_W must be at least 2");
      end
   endgenerate

   logic [DIV_W-1:0] div_q;
   logic             div_load, div_zero_load, ack_stb, expire;
   logic             pending, overrun;

   pit_regbank #(
      .DIV_W(DIV_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ACK_ANY_ACCESS(ACK_ANY_ACCESS)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr), .rd(bus_rd),
      .addr(bus_addr), .wdata(bus_wdata), .pending(pending), .overrun(overrun),
      .div_q(div_q), .div_load(div_load), .div_zero_load(div_zero_load),
      .ack_stb(ack_stb), .rdata(bus_rdata)
   );

   pit_divider #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .div_q(div_q),
      .load(div_load), .expire(expire)
   );

   pit_request u_req (
      .clk(clk), .rst_n(rst_n), .expire(expire), .ack(ack_stb),
      .clr(div_zero_load), .pending(pending), .overrun(overrun)
   );

   assign irq = pending;

   // R2: a stopped timer stays silent
   p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((div_q == '0) && !irq) |=> !irq);
   // R9: read data idles at zero
   p_rdata_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && bus_rd) |-> (bus_rdata == '0));
endmodule

// File: tb/periodic_irq_timer_bench.sv
`timescale 1ns/1ps
module periodic_irq_timer_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       irq;
   int         total = 0;
   int         bad = 0;
   logic [7:0] rv;

   always #2.5 clk = ~clk;

   periodic_irq_timer u_periodic_irq_timer (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
      bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0; bus_rd = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         tick_en = 1'b1;
         @(negedge clk);
      end
      tick_en = 1'b0;
   endtask

   initial begin
      #750000;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 irq", irq, 0);
      bus_read(2'd0, rv); check("R1 divisor", rv, 0);
      bus_read(2'd1, rv); check("R1 status", rv, 0);
      // R9 idle read data
      check("R9 idle rdata", bus_rdata, 0);
      // R2 off: ticks do nothing
      ticks(300);
      check("R2 off irq", irq, 0);

      // R3 sweep all divisors, two periods each
      for (int n = 1; n <= 255; n++) begin
         bus_write(2'd0, 8'(n));
         if (n > 1) begin
            ticks(n - 1);
            check("R3 early", irq, 0);
         end
         ticks(1);
         check("R3 first", irq, 1);
         bus_write(2'd2, 8'd0);
         check("R6 ack", irq, 0);
         if (n > 1) begin
            ticks(n - 1);
            check("R3 early2", irq, 0);
         end
         ticks(1);
         check("R3 second", irq, 1);
         bus_read(2'd1, rv);
         check("R8 no overrun", rv, 1);
         bus_write(2'd2, 8'd0);
      end
      bus_read(2'd0, rv); check("R9 divisor readback", rv, 255);

      // R8 overrun and R6 ack by read
      bus_write(2'd0, 8'd3);
      ticks(6);
      check("R5 held", irq, 1);
      bus_read(2'd1, rv); check("R8 overrun status", rv, 3);
      bus_read(2'd2, rv); check("R6 ack read data", rv, 0);
      bus_read(2'd1, rv); check("R6 cleared status", rv, 0);
      check("R6 irq low", irq, 0);

      // R5 hold over idle time
      ticks(3);
      repeat (40) @(negedge clk);
      check("R5 hold idle", irq, 1);

      // R7 zero write clears pending and count
      bus_write(2'd0, 8'd0);
      check("R7 irq", irq, 0);
      bus_read(2'd1, rv); check("R7 status", rv, 0);
      ticks(50);
      check("R2 after zero", irq, 0);

      // R4 rewrite mid-count with smaller divisor
      bus_write(2'd0, 8'd10);
      ticks(7);
      bus_write(2'd0, 8'd4);
      ticks(3);
      check("R4 early", irq, 0);
      ticks(1);
      check("R4 fire", irq, 1);
      bus_write(2'd2, 8'd0);

      // R3 sparse ticks
      bus_write(2'd0, 8'd4);
      for (int k = 0; k < 3; k++) begin
         ticks(1);
         repeat (2) @(negedge clk);
      end
      check("R3 sparse early", irq, 0);
      ticks(1);
      check("R3 sparse fire", irq, 1);
      bus_write(2'd2, 8'd0);

      // R10 ack coincides with period end
      bus_write(2'd0, 8'd2);
      ticks(2);
      check("R10 setup", irq, 1);
      ticks(1);
      tick_en = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd2;
      @(negedge clk);
      tick_en = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
      check("R10 irq", irq, 1);
      bus_read(2'd1, rv); check("R10 status", rv, 1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule